// File: doc/BRIEF.md
# SD/MMC Host Command Register Front End

This block is the register-facing half of a simple SD/MMC host controller. Software programs a transfer buffer address, a command argument and, for data commands, a block length and a block count, each stored as the value minus one. It then writes a packed command word. That write launches the command: the block decodes the word into a descriptor (opcode, response class, command kind, open-drain mode, busy wait, read direction) and issues a one-cycle start pulse to a downstream transfer engine that handles the card bus and the data movement.

The engine reports command completion, data completion and command timeout, and presents a 128-bit response. The block tracks each command through a command phase and an optional data phase. It accepts only the engine events that fit the current phase. It latches the response into four readable words and raises write-one-to-clear interrupt status bits, gated by an enable mask onto a single interrupt line. It also samples the card-present and write-protect inputs, and flags each change of card presence.

Top module: `sdh_regfront`

## Requirements
- R1: After reset, status, enable, interrupt, busy and start are all zero, and a status read returns 0.
- R2: A write to the command register (offset 0x0C) while idle gives `cmd_start` high for exactly the one cycle after the write edge. The descriptor fields are decoded from the written word: opcode bits [5:0], open-drain bit 6, response class bits [9:8], busy wait bit 11, command kind bits [13:12], read direction bit 15. `cmd_busy` goes high with the pulse.
- R3: Block length (0x24) and block count (0x28) keep only bits [10:0] of the written value, and read back and drive `blk_len_m1`/`blk_cnt_m1` as written. A command has a data phase unless both are zero.
- R4: A command-done event in the command phase without a timeout sets status bit 0. For a command with no data phase it also clears `cmd_busy`.
- R5: For a data command, a data-done event before the command has ended is ignored. After command end, data-done sets status bit 1 and clears `cmd_busy`.
- R6: A timeout in the command phase sets status bit 3 and clears `cmd_busy` without setting bit 0, even when command-done arrives in the same cycle. The response words are then left unchanged.
- R7: On command end, a short response class (1 or 3) loads word 0 (0x14) with `eng_resp[31:0]` and clears words 1 to 3. The long class (2) loads word k (0x14+4k) with `eng_resp[32k+31:32k]`. Class 0 leaves the words unchanged.
- R8: Writing the status register (0x00) clears exactly the bits written as one. A bit set by an event in the same cycle as its clear stays set.
- R9: `irq` is high exactly when some status bit and its enable bit (0x04) are both set. Status bits latch whatever the enable.
- R10: The card-state register (0x2C) reads card present in bit 0 and read-only in bit 1, one cycle after the inputs. Any change of card presence sets status bit 2; a change of read-only alone does not.
- R11: A command write while `cmd_busy` is high produces no start pulse and leaves the descriptor unchanged. It sets the sticky status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| cmd_start | output | 1 | One-cycle command launch pulse |
| cmd_opcode | output | 6 | Decoded command opcode |
| cmd_rsp_class | output | 2 | Response class: 0 none, 1 short, 2 long, 3 short without CRC |
| cmd_kind | output | 2 | Command kind: 0 broadcast, 1 broadcast with response, 2 addressed, 3 addressed with data |
| cmd_open_drain | output | 1 | Open-drain bus mode requested |
| cmd_busy_wait | output | 1 | Wait for card busy after response |
| cmd_read | output | 1 | Data direction is card to host |
| cmd_data_phase | output | 1 | Command carries a data phase |
| cmd_arg | output | 32 | Command argument register |
| buf_addr | output | 32 | Transfer buffer address register |
| blk_len_m1 | output | 11 | Block length minus one |
| blk_cnt_m1 | output | 11 | Block count minus one |
| cmd_busy | output | 1 | A command is in progress |
| eng_cmd_done | input | 1 | Engine: command phase complete |
| eng_data_done | input | 1 | Engine: data phase complete |
| eng_timeout | input | 1 | Engine: command response timed out |
| eng_resp | input | 128 | Engine: response bits |
| card_present | input | 1 | Card inserted |
| card_ro | input | 1 | Card write-protected |

## Verification
The assertions check five properties on every cycle. The start pulse lasts one cycle and fires only from idle. A command write during busy raises the overrun bit. A rise of the end-of-command bit never follows a timeout. The end-of-data bit rises only out of the data phase. Every change of card presence sets the card-change bit. The bench scenarios cover what needs chosen stimulus and values read back: correct decoding of each descriptor field, the placement of short and long responses in the four words, the masking of length and count to 11 bits, the interaction of clear and set in one cycle, and the enable gating of the interrupt line.

// File: rtl/sdh_pkg.sv
package sdh_pkg;

    localparam int unsigned ADDR_W = 6;
    localparam int unsigned OPC_W  = 6;
    localparam int unsigned CNT_W  = 11;
    localparam int unsigned STAT_W = 5;
    localparam int unsigned RESP_WORDS = 4;

    localparam logic [ADDR_W-1:0] OFF_STATUS = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_ENABLE = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_BUF    = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_CMD    = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_ARG    = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_RESP0  = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_RESP1  = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_RESP2  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_RESP3  = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_BLEN   = 6'h24;
    localparam logic [ADDR_W-1:0] OFF_BCNT   = 6'h28;
    localparam logic [ADDR_W-1:0] OFF_CARD   = 6'h2C;

    localparam int unsigned ST_CMD  = 0;
    localparam int unsigned ST_DATA = 1;
    localparam int unsigned ST_CARD = 2;
    localparam int unsigned ST_TMO  = 3;
    localparam int unsigned ST_OVR  = 4;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_SHORT = 2'd1,
        RSP_LONG  = 2'd2,
        RSP_NOCRC = 2'd3
    } rsp_cls_e;

    typedef enum logic [1:0] {
        KIND_BCAST     = 2'd0,
        KIND_BCAST_RSP = 2'd1,
        KIND_ADDR      = 2'd2,
        KIND_ADDR_DATA = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        rsp_cls_e         rsp;
        cmd_kind_e        kind;
        logic             open_drain;
        logic             busy_wait;
        logic             rd_dir;
    } cmd_desc_t;

    function automatic cmd_desc_t unpack_cmd(input logic [15:0] w);
        cmd_desc_t d;
        d.opcode     = w[OPC_W-1:0];
        d.open_drain = w[6];
        d.rsp        = rsp_cls_e'(w[9:8]);
        d.busy_wait  = w[11];
        d.kind       = cmd_kind_e'(w[13:12]);
        d.rd_dir     = w[15];
        return d;
    endfunction

endpackage

// File: rtl/sdh_cmd_seq.sv
module sdh_cmd_seq
    import sdh_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_wr,
    input  logic [15:0] cmd_word,
    input  logic      has_data,
    input  logic      eng_cmd_done,
    input  logic      eng_data_done,
    input  logic      eng_timeout,
    output logic      start,
    output cmd_desc_t desc,
    output logic      data_phase,
    output phase_e    phase,
    output logic      ev_cmd_end,
    output logic      ev_data_end,
    output logic      ev_timeout,
    output logic      ev_overrun
);

    always_comb begin
        ev_timeout  = (phase == PH_CMD) && eng_timeout;
        ev_cmd_end  = (phase == PH_CMD) && eng_cmd_done && !eng_timeout;
        ev_data_end = (phase == PH_DATA) && eng_data_done;
        ev_overrun  = cmd_wr && (phase != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            start      <= 1'b0;
            desc       <= '0;
            data_phase <= 1'b0;
        end else begin
            start <= 1'b0;
            unique case (phase)
                PH_IDLE: if (cmd_wr) begin
                    phase      <= PH_CMD;
                    start      <= 1'b1;
                    desc       <= unpack_cmd(cmd_word);
                    data_phase <= has_data;
                end
                PH_CMD: begin
                    if (ev_timeout)
                        phase <= PH_IDLE;
                    else if (ev_cmd_end)
                        phase <= data_phase ? PH_DATA : PH_IDLE;
                end
                PH_DATA: if (ev_data_end) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdh_irq_ctrl.sv
module sdh_irq_ctrl #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    input  logic         en_wr,
    input  logic [W-1:0] en_data,
    output logic [W-1:0] status,
    output logic [W-1:0] enable,
    output logic         irq
);

    logic [W-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_mask : '0;
    assign irq     = |(status & enable);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr_eff) | set_vec;
            if (en_wr) enable <= en_data;
        end
    end

endmodule

// File: rtl/sdh_card_mon.sv
module sdh_card_mon (
    input  logic clk,
    input  logic rst,
    input  logic card_present,
    input  logic card_ro,
    output logic present_q,
    output logic ro_q,
    output logic presence_chg
);

    assign presence_chg = card_present ^ present_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            present_q <= card_present;
            ro_q      <= card_ro;
        end else begin
            present_q <= card_present;
            ro_q      <= card_ro;
        end
    end

endmodule

// File: rtl/sdh_regfront.sv
module sdh_regfront
    import sdh_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq,
    output logic               cmd_start,
    output logic [OPC_W-1:0]   cmd_opcode,
    output logic [1:0]         cmd_rsp_class,
    output logic [1:0]         cmd_kind,
    output logic               cmd_open_drain,
    output logic               cmd_busy_wait,
    output logic               cmd_read,
    output logic               cmd_data_phase,
    output logic [31:0]        cmd_arg,
    output logic [31:0]        buf_addr,
    output logic [CNT_W-1:0]   blk_len_m1,
    output logic [CNT_W-1:0]   blk_cnt_m1,
    output logic               cmd_busy,
    input  logic               eng_cmd_done,
    input  logic               eng_data_done,
    input  logic               eng_timeout,
    input  logic [32*RESP_WORDS-1:0] eng_resp,
    input  logic               card_present,
    input  logic               card_ro
);

    logic              wr_status, wr_enable, wr_cmd;
    cmd_desc_t         desc;
    phase_e            seq_phase;
    logic              ev_cmd_end, ev_data_end, ev_timeout, ev_overrun;
    logic [STAT_W-1:0] set_vec, status_q, enable_q;
    logic              present_q, ro_q, presence_chg;
    logic [31:0]       resp_q [RESP_WORDS];

    assign wr_status = bus_we && (bus_addr == OFF_STATUS);
    assign wr_enable = bus_we && (bus_addr == OFF_ENABLE);
    assign wr_cmd    = bus_we && (bus_addr == OFF_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_arg    <= '0;
            buf_addr   <= '0;
            blk_len_m1 <= '0;
            blk_cnt_m1 <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                OFF_ARG:  cmd_arg    <= bus_wdata;
                OFF_BUF:  buf_addr   <= bus_wdata;
                OFF_BLEN: blk_len_m1 <= bus_wdata[CNT_W-1:0];
                OFF_BCNT: blk_cnt_m1 <= bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    sdh_cmd_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .cmd_wr        (wr_cmd),
        .cmd_word      (bus_wdata[15:0]),
        .has_data      ((|blk_len_m1) || (|blk_cnt_m1)),
        .eng_cmd_done  (eng_cmd_done),
        .eng_data_done (eng_data_done),
        .eng_timeout   (eng_timeout),
        .start         (cmd_start),
        .desc          (desc),
        .data_phase    (cmd_data_phase),
        .phase         (seq_phase),
        .ev_cmd_end    (ev_cmd_end),
        .ev_data_end   (ev_data_end),
        .ev_timeout    (ev_timeout),
        .ev_overrun    (ev_overrun)
    );

    assign cmd_opcode     = desc.opcode;
    assign cmd_rsp_class  = desc.rsp;
    assign cmd_kind       = desc.kind;
    assign cmd_open_drain = desc.open_drain;
    assign cmd_busy_wait  = desc.busy_wait;
    assign cmd_read       = desc.rd_dir;
    assign cmd_busy       = (seq_phase != PH_IDLE);

    // Response words: long class fills all, short classes fill word 0 only.
    generate
        for (genvar k = 0; k < RESP_WORDS; k++) begin : g_resp
            always_ff @(posedge clk) begin
                if (rst) begin
                    resp_q[k] <= '0;
                end else if (ev_cmd_end && desc.rsp != RSP_NONE) begin
                    if (desc.rsp == RSP_LONG)
                        resp_q[k] <= eng_resp[32*k +: 32];
                    else
                        resp_q[k] <= (k == 0) ? eng_resp[31:0] : 32'h0;
                end
            end
        end
    endgenerate

    sdh_card_mon u_card (
        .clk          (clk),
        .rst          (rst),
        .card_present (card_present),
        .card_ro      (card_ro),
        .present_q    (present_q),
        .ro_q         (ro_q),
        .presence_chg (presence_chg)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[ST_CMD]  = ev_cmd_end;
        set_vec[ST_DATA] = ev_data_end;
        set_vec[ST_CARD] = presence_chg;
        set_vec[ST_TMO]  = ev_timeout;
        set_vec[ST_OVR]  = ev_overrun;
    end

    sdh_irq_ctrl #(.W(STAT_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_wr   (wr_status),
        .clr_mask (bus_wdata[STAT_W-1:0]),
        .en_wr    (wr_enable),
        .en_data  (bus_wdata[STAT_W-1:0]),
        .status   (status_q),
        .enable   (enable_q),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_STATUS: bus_rdata[STAT_W-1:0] = status_q;
            OFF_ENABLE: bus_rdata[STAT_W-1:0] = enable_q;
            OFF_BUF:    bus_rdata = buf_addr;
            OFF_ARG:    bus_rdata = cmd_arg;
            OFF_RESP0:  bus_rdata = resp_q[0];
            OFF_RESP1:  bus_rdata = resp_q[1];
            OFF_RESP2:  bus_rdata = resp_q[2];
            OFF_RESP3:  bus_rdata = resp_q[3];
            OFF_BLEN:   bus_rdata[CNT_W-1:0] = blk_len_m1;
            OFF_BCNT:   bus_rdata[CNT_W-1:0] = blk_cnt_m1;
            OFF_CARD:   bus_rdata[1:0] = {ro_q, present_q};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sdh_regfront_chk.sv
module sdh_regfront_chk
    import sdh_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_start,
    input logic              cmd_busy,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              eng_timeout,
    input logic              card_present,
    input logic [STAT_W-1:0] status,
    input phase_e            phase
);

    // R2: launch pulse is a single cycle and only leaves idle
    a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> !cmd_start);
    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> $past(phase == PH_IDLE));

    // R11: command write while busy records overrun
    a_r11_overrun_flag: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFF_CMD && cmd_busy) |=> status[ST_OVR]);

    // R6: end-of-command never rises on a timeout
    a_r6_timeout_suppress: assert property (@(posedge clk) disable iff (rst)
        $rose(status[ST_CMD]) |-> !$past(eng_timeout));

    // R5: end-of-data only comes out of the data phase
    a_r5_data_after_cmd: assert property (@(posedge clk) disable iff (rst)
        $rose(status[ST_DATA]) |-> $past(phase == PH_DATA));

    // R10: presence change always flags status bit 2
    a_r10_card_change: assert property (@(posedge clk) disable iff (rst)
        (card_present != $past(card_present)) |=> status[ST_CARD]);

endmodule

bind sdh_regfront sdh_regfront_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_start    (cmd_start),
    .cmd_busy     (cmd_busy),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .eng_timeout  (eng_timeout),
    .card_present (card_present),
    .status       (status_q),
    .phase        (seq_phase)
);

// File: tb/sdh_regfront_test.sv
module sdh_regfront_test;
    import sdh_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq, cmd_start, cmd_open_drain, cmd_busy_wait, cmd_read, cmd_data_phase, cmd_busy;
    logic [OPC_W-1:0] cmd_opcode;
    logic [1:0] cmd_rsp_class, cmd_kind;
    logic [31:0] cmd_arg, buf_addr;
    logic [CNT_W-1:0] blk_len_m1, blk_cnt_m1;
    logic eng_cmd_done = 1'b0, eng_data_done = 1'b0, eng_timeout = 1'b0;
    logic [127:0] eng_resp = '0;
    logic card_present = 1'b0, card_ro = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sdh_regfront uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .cmd_start(cmd_start), .cmd_opcode(cmd_opcode), .cmd_rsp_class(cmd_rsp_class),
        .cmd_kind(cmd_kind), .cmd_open_drain(cmd_open_drain), .cmd_busy_wait(cmd_busy_wait),
        .cmd_read(cmd_read), .cmd_data_phase(cmd_data_phase), .cmd_arg(cmd_arg),
        .buf_addr(buf_addr), .blk_len_m1(blk_len_m1), .blk_cnt_m1(blk_cnt_m1),
        .cmd_busy(cmd_busy), .eng_cmd_done(eng_cmd_done), .eng_data_done(eng_data_done),
        .eng_timeout(eng_timeout), .eng_resp(eng_resp), .card_present(card_present),
        .card_ro(card_ro)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input bit cd, input bit dd, input bit to);
        @(negedge clk);
        eng_cmd_done = cd; eng_data_done = dd; eng_timeout = to;
        @(negedge clk);
        eng_cmd_done = 0; eng_data_done = 0; eng_timeout = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(OFF_STATUS, v);
        check("R1 status", v, 0);
        check("R1 irq", irq, 0);
        check("R1 busy", cmd_busy, 0);
        check("R1 start", cmd_start, 0);
    endtask

    task automatic t_short_cmd();
        logic [31:0] v;
        wr(OFF_ENABLE, 32'h0);
        wr(OFF_ARG, 32'h1234_5678);
        wr(OFF_CMD, 32'h214D);   // opcode 13, open-drain, short rsp, addressed
        check("R2 start", cmd_start, 1);
        check("R2 opcode", cmd_opcode, 13);
        check("R2 rsp", cmd_rsp_class, 1);
        check("R2 kind", cmd_kind, 2);
        check("R2 od", cmd_open_drain, 1);
        check("R2 bw", cmd_busy_wait, 0);
        check("R2 rd", cmd_read, 0);
        check("R2 arg", cmd_arg, 32'h1234_5678);
        check("R2 busy", cmd_busy, 1);
        check("R3 no data", cmd_data_phase, 0);
        @(negedge clk);
        check("R2 pulse one cycle", cmd_start, 0);
        eng_resp = {32'hDDDD_0004, 32'hCCCC_0003, 32'hBBBB_0002, 32'hAAAA_0001};
        pulse(1, 0, 0);
        rd(OFF_STATUS, v);
        check("R4 status", v, 32'h1);
        check("R4 busy end", cmd_busy, 0);
        check("R9 masked irq", irq, 0);
        rd(OFF_RESP0, v); check("R7 short w0", v, 32'hAAAA_0001);
        rd(OFF_RESP1, v); check("R7 short w1", v, 0);
        wr(OFF_ENABLE, 32'h1);
        check("R9 irq enabled", irq, 1);
        wr(OFF_STATUS, 32'h1);
        rd(OFF_STATUS, v);
        check("R8 cleared", v, 0);
        check("R9 irq low", irq, 0);
    endtask

    task automatic t_data_cmd();
        logic [31:0] v;
        wr(OFF_BLEN, 32'h0001_FFFF);
        rd(OFF_BLEN, v); check("R3 len mask", v, 32'h7FF);
        wr(OFF_BLEN, 32'd511);
        wr(OFF_BCNT, 32'd7);
        rd(OFF_BLEN, v); check("R3 len", v, 511);
        rd(OFF_BCNT, v); check("R3 cnt", v, 7);
        check("R3 cnt port", blk_cnt_m1, 7);
        wr(OFF_CMD, 32'hB112);   // opcode 18, short rsp, data, read
        check("R2 read dir", cmd_read, 1);
        check("R2 kind data", cmd_kind, 3);
        check("R3 data phase", cmd_data_phase, 1);
        pulse(0, 1, 0);
        rd(OFF_STATUS, v); check("R5 early data ignored", v, 0);
        pulse(1, 0, 0);
        rd(OFF_STATUS, v); check("R5 cmd end", v, 1);
        check("R5 still busy", cmd_busy, 1);
        pulse(0, 1, 0);
        rd(OFF_STATUS, v); check("R5 data end", v, 3);
        check("R5 busy end", cmd_busy, 0);
        wr(OFF_STATUS, 32'h3);
        wr(OFF_BLEN, 0);
        wr(OFF_BCNT, 0);
    endtask

    task automatic t_timeout_long();
        logic [31:0] v;
        wr(OFF_CMD, 32'h1202);   // opcode 2, long rsp
        eng_resp = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
        pulse(1, 0, 1);
        rd(OFF_STATUS, v); check("R6 timeout only", v, 32'h8);
        check("R6 busy end", cmd_busy, 0);
        rd(OFF_RESP0, v); check("R6 resp kept", v, 32'hAAAA_0001);
        wr(OFF_STATUS, 32'h8);
        wr(OFF_CMD, 32'h1202);
        pulse(1, 0, 0);
        rd(OFF_RESP0, v); check("R7 long w0", v, 32'h1111_1111);
        rd(OFF_RESP1, v); check("R7 long w1", v, 32'h2222_2222);
        rd(OFF_RESP2, v); check("R7 long w2", v, 32'h3333_3333);
        rd(OFF_RESP3, v); check("R7 long w3", v, 32'h4444_4444);
        wr(OFF_STATUS, 32'h1);
        wr(OFF_CMD, 32'h0000);   // no response class
        eng_resp = '1;
        pulse(1, 0, 0);
        rd(OFF_RESP3, v); check("R7 none keeps", v, 32'h4444_4444);
        wr(OFF_STATUS, 32'h1);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        wr(OFF_CMD, 32'h0105);
        @(negedge clk);
        wr(OFF_CMD, 32'h0109);
        check("R11 no start", cmd_start, 0);
        check("R11 desc kept", cmd_opcode, 5);
        rd(OFF_STATUS, v); check("R11 overrun", v, 32'h10);
        pulse(1, 0, 0);
        rd(OFF_STATUS, v); check("R11 sticky", v, 32'h11);
        wr(OFF_STATUS, 32'h10);
        rd(OFF_STATUS, v); check("R8 zeros keep", v, 32'h1);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        wr(OFF_CMD, 32'h0107);
        @(negedge clk);
        bus_addr = OFF_STATUS; bus_wdata = 32'h1; bus_we = 1; eng_cmd_done = 1;
        @(negedge clk);
        bus_we = 0; eng_cmd_done = 0;
        rd(OFF_STATUS, v); check("R8 set wins", v, 32'h1);
        wr(OFF_STATUS, 32'h1);
    endtask

    task automatic t_card();
        logic [31:0] v;
        @(negedge clk); card_present = 1;
        @(negedge clk);
        rd(OFF_CARD, v); check("R10 present", v, 1);
        rd(OFF_STATUS, v); check("R10 insert flag", v, 32'h4);
        wr(OFF_STATUS, 32'h4);
        @(negedge clk); card_ro = 1;
        @(negedge clk);
        rd(OFF_CARD, v); check("R10 ro", v, 3);
        rd(OFF_STATUS, v); check("R10 ro no flag", v, 0);
        wr(OFF_ENABLE, 32'h4);
        @(negedge clk); card_present = 0;
        @(negedge clk);
        rd(OFF_STATUS, v); check("R10 removal flag", v, 32'h4);
        check("R9 card irq", irq, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_short_cmd();
        t_data_cmd();
        t_timeout_long();
        t_overrun();
        t_set_wins();
        t_card();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule